// File: doc/BRIEF.md
# Single-Cycle Barrel Shift and Rotate Unit

This unit moves a 32-bit operand left or right by any distance from 0 to 31 in one operation. It is meant to sit in the execute stage of a small processor. It provides five operations: logical left, logical right, arithmetic right, rotate left and rotate right. Every operation goes through a logarithmic stage network, so no operation is built from repeated one-bit steps. A request presented with `valid_i` is registered on the next rising edge, and the outputs change there.

The unit keeps a carry flag and a zero flag. The carry is always the first bit to leave the word, whatever the distance: original bit 0 for right operations and original bit 31 for left operations. For a distance of one it therefore matches an ordinary one-bit shift. For longer distances it does not match a chain of one-bit shifts. The flags change only when flag writing is enabled. Result writing has its own enable and strobe. A request with flags enabled and the result disabled tests a bit without disturbing the destination register.

The amount input is 9 bits wide, matching an immediate field. Only its low 5 bits give the distance, so distances wrap modulo 32.

Top module: `shift_unit`

## Requirements
- R1: Opcode encoding on `op_i` is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate left, 4 = rotate right. For a valid request with `res_we_i` set, `result_o` shows the moved operand one rising edge later and `res_wr_o` pulses high for that one cycle.
- R2: The distance is `amount_i[4:0]`. Bits 8:5 of `amount_i` have no effect on the result or the flags.
- R3: Arithmetic right fills the vacated high bits with original bit 31. Logical shifts fill vacated bits with zero. Rotates reinsert the bits that leave at the opposite end.
- R4: For opcodes 1, 2 and 4 with `flag_we_i` set, `carry_o` becomes original operand bit 0 for every distance, including 0.
- R5: For opcodes 0 and 3 with `flag_we_i` set, `carry_o` becomes original operand bit 31 for every distance, including 0.
- R6: When no valid legal request has `flag_we_i` set, `carry_o` and `zero_o` keep their values.
- R7: With `flag_we_i` set, `zero_o` becomes 1 exactly when the 32-bit moved value is zero. This holds even when `res_we_i` is clear.
- R8: When no valid legal request has `res_we_i` set, `res_wr_o` is 0 the next cycle and `result_o` keeps its value.
- R9: A distance of 0 passes the operand through unchanged for every opcode.
- R10: Opcodes 5, 6 and 7 are reserved. A valid request with one of them changes no output and raises no strobe.
- R11: While `rst_ni` is low, `result_o`, `carry_o`, `zero_o` and `res_wr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 3 | Operation code (see R1) |
| operand_i | input | 32 | Value to move |
| amount_i | input | 9 | Distance; only bits 4:0 are used |
| flag_we_i | input | 1 | Update carry and zero flags |
| res_we_i | input | 1 | Write back the result |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| res_wr_o | output | 1 | One-cycle result write strobe |

## Verification
The bench targets multi-bit distances where a design that takes the carry from the last bit shifted out would differ. Shifting 0x0000_0002 right by 2 must give carry 0, not 1. It checks arithmetic right on negative values, which a design filling with zeros would get wrong in the top bits. It also checks distance 0 with the flags enabled, where a design that leaves the carry alone would keep a stale value. Other targets are amounts with high bits set, which expose designs that use more than five bits; flag-only bit tests, where a wrongly gated design would raise the strobe or overwrite the result; and reserved opcodes, which must leave every output alone. A reference model built from one-bit steps checks the results of a random run.

// File: rtl/shift_pkg.sv
`timescale 1ns/1ps
package shift_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = 9;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4
  } shift_op_e;

  typedef struct packed {
    logic left;
    logic rotate;
    logic arith;
    logic legal;
  } shift_ctl_t;

  function automatic shift_ctl_t decode_op(input logic [2:0] op);
    shift_ctl_t c;
    c = '0;
    unique case (op)
      OP_SHL:  begin c.left = 1'b1; c.legal = 1'b1; end
      OP_SHR:  begin c.legal = 1'b1; end
      OP_SAR:  begin c.arith = 1'b1; c.legal = 1'b1; end
      OP_ROL:  begin c.left = 1'b1; c.rotate = 1'b1; c.legal = 1'b1; end
      OP_ROR:  begin c.rotate = 1'b1; c.legal = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/shift_core.sv
`timescale 1ns/1ps
// Log-depth right mover; left operations go through a bit reversal on both sides.
module shift_core #(
  parameter int unsigned W    = 32,
  localparam int unsigned SH_W = $clog2(W)
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] dist_i,
  input  logic            left_i,
  input  logic            rotate_i,
  input  logic            arith_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0]          rev_in;
  logic [W-1:0]          rev_out;
  logic [SH_W:0][W-1:0]  stg;
  logic                  fill;

  assign fill = arith_i & ~left_i & data_i[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stg[SH_W][W-1-i];
  end

  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i + STEP < W) begin : g_in
        assign stg[k+1][i] = dist_i[k] ? stg[k][i+STEP] : stg[k][i];
      end else begin : g_edge
        assign stg[k+1][i] = dist_i[k] ? (rotate_i ? stg[k][i+STEP-W] : fill)
                                       : stg[k][i];
      end
    end
  end

  assign data_o = left_i ? rev_out : stg[SH_W];
endmodule

// File: rtl/carry_pick.sv
`timescale 1ns/1ps
// First bit to leave the word: only the two end bits are tapped.
module carry_pick #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] data_i,
  input  logic         left_i,
  output logic         carry_o
);
  assign carry_o = left_i ? data_i[W-1] : data_i[0];
endmodule

// File: rtl/flag_regs.sv
`timescale 1ns/1ps
module flag_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flag_en_i,
  input  logic         res_en_i,
  input  logic [W-1:0] value_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         res_wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
    end else if (flag_en_i) begin
      carry_o <= carry_i;
      zero_o  <= ~|value_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      res_wr_o <= 1'b0;
    end else begin
      res_wr_o <= res_en_i;
      if (res_en_i) result_o <= value_i;
    end
  end
endmodule

// File: rtl/shift_unit.sv
`timescale 1ns/1ps
module shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = AMT_W,
  localparam int unsigned SH_W = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] operand_i,
  input  logic [AW-1:0] amount_i,
  input  logic          flag_we_i,
  input  logic          res_we_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          res_wr_o
);
  shift_ctl_t     ctl;
  logic [DW-1:0]  moved;
  logic           carry_nxt;
  logic           take;
  logic [AW-1:0]  unused_amt;

  assign ctl        = decode_op(op_i);
  assign take       = valid_i & ctl.legal;
  assign unused_amt = amount_i;

  shift_core #(.W(DW)) i_core (
    .data_i   (operand_i),
    .dist_i   (amount_i[SH_W-1:0]),
    .left_i   (ctl.left),
    .rotate_i (ctl.rotate),
    .arith_i  (ctl.arith),
    .data_o   (moved)
  );

  carry_pick #(.W(DW)) i_carry (
    .data_i  (operand_i),
    .left_i  (ctl.left),
    .carry_o (carry_nxt)
  );

  flag_regs #(.W(DW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_en_i (take & flag_we_i),
    .res_en_i  (take & res_we_i),
    .value_i   (moved),
    .carry_i   (carry_nxt),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .zero_o    (zero_o),
    .res_wr_o  (res_wr_o)
  );
endmodule

// File: rtl/shift_unit_chk.sv
`timescale 1ns/1ps
module shift_unit_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic [DW-1:0] operand_i,
  input logic [AW-1:0] amount_i,
  input logic          flag_we_i,
  input logic          res_we_i,
  input logic [DW-1:0] result_o,
  input logic          carry_o,
  input logic          zero_o,
  input logic          res_wr_o
);
  logic legal, right_op, left_op;
  assign legal    = op_i <= 3'd4;
  assign left_op  = (op_i == 3'd0) || (op_i == 3'd3);
  assign right_op = (op_i == 3'd1) || (op_i == 3'd2) || (op_i == 3'd4);

  AST_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && legal && res_we_i |=> res_wr_o); // R1
  AST_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && legal && res_we_i) |=> !res_wr_o && $stable(result_o)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && legal && flag_we_i) |=> $stable(carry_o) && $stable(zero_o)); // R6
  AST_CARRY_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && right_op && flag_we_i |=> carry_o == $past(operand_i[0])); // R4
  AST_CARRY_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && left_op && flag_we_i |=> carry_o == $past(operand_i[DW-1])); // R5
  AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && legal && flag_we_i && res_we_i |=> zero_o == (result_o == '0)); // R7
  AST_DIST_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && legal && res_we_i && amount_i[4:0] == 5'd0 |=> result_o == $past(operand_i)); // R9
  AST_RSVD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !legal |=> !res_wr_o && $stable(result_o) && $stable(carry_o) && $stable(zero_o)); // R10
  always_comb if (!rst_ni) begin
    AST_RESET_CLEAR: assert (result_o == '0 && !carry_o && !zero_o && !res_wr_o); // R11
  end
endmodule

bind shift_unit shift_unit_chk #(.DW(DW), .AW(AW)) i_chk (.*);

// File: tb/test_shift_unit.sv
`timescale 1ns/1ps
module test_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] operand = '0;
  logic [8:0]  amount = '0;
  logic        fwe = 1'b0, rwe = 1'b0;
  logic [31:0] result;
  logic        carry, zero, res_wr;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    logic        wr;
    logic [31:0] res;
    logic        c;
    logic        z;
  } item_t;
  item_t q[$];

  logic [31:0] m_res = '0;
  logic        m_c = 1'b0, m_z = 1'b0;

  always #4 clk = ~clk;

  shift_unit i_shift_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .operand_i(operand), .amount_i(amount), .flag_we_i(fwe), .res_we_i(rwe),
    .result_o(result), .carry_o(carry), .zero_o(zero), .res_wr_o(res_wr)
  );

  // Reference: repeated one-bit steps for the value, end bit for the carry.
  function automatic logic [31:0] ref_move(input logic [2:0] o, input logic [31:0] x,
                                           input int n);
    logic [31:0] v = x;
    for (int s = 0; s < n; s++) begin
      case (o)
        3'd0: v = {v[30:0], 1'b0};
        3'd1: v = {1'b0, v[31:1]};
        3'd2: v = {v[31], v[31:1]};
        3'd3: v = {v[30:0], v[31]};
        default: v = {v[0], v[31:1]};
      endcase
    end
    return v;
  endfunction

  task automatic issue(input string req, input logic [2:0] o, input logic [31:0] x,
                       input logic [8:0] a, input logic f, input logic r);
    item_t it;
    logic [31:0] mv;
    @(negedge clk);
    valid = 1'b1; op = o; operand = x; amount = a; fwe = f; rwe = r;
    if (o <= 3'd4) begin
      mv = ref_move(o, x, int'(a[4:0]));
      if (f) begin
        m_c = (o == 3'd0 || o == 3'd3) ? x[31] : x[0];
        m_z = (mv == 32'd0);
      end
      if (r) m_res = mv;
      it.wr = r;
    end else begin
      it.wr = 1'b0;
    end
    it.req = req; it.res = m_res; it.c = m_c; it.z = m_z;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; fwe = 1'b0; rwe = 1'b0;
  endtask

  // Monitor: samples 2 ns after the rising edge that registers each request.
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        tests++;
        if (res_wr !== e.wr || result !== e.res || carry !== e.c || zero !== e.z) begin
          fails++;
          $display("FAIL %s: got wr=%b res=%h c=%b z=%b, expected wr=%b res=%h c=%b z=%b",
                   e.req, res_wr, result, carry, zero, e.wr, e.res, e.c, e.z);
        end
      end else if (res_wr !== 1'b0) begin
        tests++; fails++;
        $display("FAIL R8: got stray res_wr=%b, expected 0", res_wr);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (result !== 32'd0 || carry !== 1'b0 || zero !== 1'b0 || res_wr !== 1'b0) begin
      fails++;
      $display("FAIL R11: got res=%h c=%b z=%b wr=%b, expected all zero",
               result, carry, zero, res_wr);
    end
    rst_n = 1'b1;
    idle();

    issue("R1 shl", 3'd0, 32'h8000_0001, 9'd4, 1, 1);
    issue("R5 shl carry from bit31", 3'd0, 32'h7000_0000, 9'd1, 1, 1);
    issue("R4 shr carry bit0 not last out", 3'd1, 32'h0000_0002, 9'd2, 1, 1);
    issue("R3 sar sign fill", 3'd2, 32'h8000_00F0, 9'd8, 1, 1);
    issue("R3 shr zero fill", 3'd1, 32'h8000_00F0, 9'd8, 1, 1);
    issue("R3 rol wrap", 3'd3, 32'hF000_0001, 9'd4, 1, 1);
    issue("R3 ror wrap", 3'd4, 32'h0000_000F, 9'd4, 1, 1);
    issue("R5 rol carry bit31", 3'd3, 32'h4000_0000, 9'd31, 1, 1);
    issue("R9 dist zero ror", 3'd4, 32'hDEAD_BEEF, 9'd0, 1, 1);
    issue("R9 R5 dist zero shl", 3'd0, 32'h8000_0000, 9'd0, 1, 1);
    issue("R2 high amount bits", 3'd1, 32'hF000_0000, 9'h1E3, 1, 1);
    issue("R7 zero set", 3'd1, 32'h0000_0001, 9'd1, 1, 1);
    issue("R6 flags held", 3'd0, 32'h8000_0000, 9'd3, 0, 1);
    issue("R7 R8 flag-only test", 3'd1, 32'h0000_0000, 9'd5, 1, 0);
    issue("R10 reserved op 6", 3'd6, 32'hFFFF_FFFF, 9'd1, 1, 1);
    issue("R10 reserved op 5", 3'd5, 32'h0000_0001, 9'd0, 1, 1);
    issue("R8 no write no flags", 3'd3, 32'h1234_5678, 9'd7, 0, 0);
    idle();
    issue("R3 sar full", 3'd2, 32'h8000_0000, 9'd31, 1, 1);
    idle();
    idle();
    for (int n = 0; n < 400; n++) begin
      issue("R1 random", 3'($urandom_range(0, 7)), $urandom, 9'($urandom),
            1'($urandom), 1'($urandom));
      if ((n % 7) == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule